// File: doc/BRIEF.md
# I2C Bus Clear Sequencer

This block frees an I2C bus on which a slave device is holding SDA low, a state that can remain after lost arbitration or an interrupted transfer. Once started, it drives a programmed number of clock pulses on SCL so that the slave can shift out the rest of its byte and let go of SDA. It can then close the bus with a STOP condition. Both lines are open-drain. The block only ever pulls a line low, through an output-enable signal, and it reads back the state of SDA.

Software sets the block up through a small register port. Settings are first written to a shadow copy. They become active only after a load bit is set. The load bit clears itself once the copy has taken place, and the copy waits until no recovery is in progress. Writing the start bit launches a recovery, and that same bit reads back as zero once the bus lines have been released. A termination mode chooses between two endings: stopping as soon as SDA is seen high, or always sending every programmed pulse. A status bit shows whether SDA was still low at the last sample. The block is meant to be used after the owning controller has been reset.

Register map, 2-bit address, 6-bit data. Address 0 is the shadow configuration: bits [3:0] hold the pulse count, bit 4 selects the STOP, and bit 5 selects early termination. Address 1 is the load bit, bit 0. Address 2 holds the start/busy bit in bit 0 and the stuck status in bit 1, which is read-only. Address 3 is a read-only copy of the active configuration, in the same layout as address 0.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, the shadow and active configurations both read 0x19: 9 pulses, STOP selected, full-count mode. Address 2 reads 0, and scl_oe and sda_oe are both low.
- R2: In full-count mode (bit 5 = 0), a recovery produces exactly N SCL pulses for a programmed count N, whatever the level of SDA.
- R3: In early-termination mode (bit 5 = 1), SDA is sampled at the end of each SCL high phase. The pulse train stops after the first pulse whose sample reads high, and it never exceeds N pulses.
- R4: With STOP selected (bit 4 = 1), the pulses are followed by this sequence: SCL low, then SDA driven low, then SCL released, then SDA released. SDA changes only while SCL is held low, except for that final release, which happens while SCL is released. With STOP not selected, sda_oe stays low for the whole recovery.
- R5: Writing 1 to address 2 bit 0 while idle starts a recovery. The bit reads 1 until both lines are released and then reads 0. Writes to address 2 while a recovery runs have no effect on it.
- R6: A write to address 0 does not change the active configuration (address 3) or the next recovery until a load takes place.
- R7: Writing 1 to address 1 bit 0 sets a pending load, which reads back as 1. The shadow is copied to the active configuration at the first cycle the block is idle, and the bit then reads 0. A load requested during a recovery is deferred until that recovery ends.
- R8: Address 2 bit 1 reads 1 when SDA was low at the last sample. With N = 0, no pulses are sent and SDA is sampled once at the start.
- R9: Every SCL pulse holds SCL low for exactly HALF_DIV clock cycles and then releases it for HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 6 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 6 | Register read data (combinational) |
| sda_in | input | 1 | Sensed SDA level, asynchronous |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench sweeps every pulse count from 0 to 10. For each count it uses a slave model that holds SDA low for every number of SCL falling edges from 0 to 12, and it runs each case in both termination modes with STOP on and off. Slaves that release before, exactly at, and after the programmed count separate early termination from full-count behaviour, and they show where the stuck status flips. The runs with STOP on and off separate the STOP sequence from a recovery with SDA left alone. Separate directed cases cover writes that happen while a recovery is running: a stop-or-restart write, and a shadow update with a load. These cases show whether the start bit and the active configuration are protected while busy and whether the load is deferred.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

    localparam int PULSE_W = 4;
    localparam int DW      = PULSE_W + 2;
    localparam int STOP_B  = PULSE_W;
    localparam int TERM_B  = PULSE_W + 1;

    localparam logic [1:0] A_CFG  = 2'd0;
    localparam logic [1:0] A_LOAD = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_ACT  = 2'd3;

    typedef struct packed {
        logic               term_imm;
        logic               stop_sel;
        logic [PULSE_W-1:0] pulses;
    } cfg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOW,
        S_HIGH,
        S_SA,
        S_SB,
        S_SC,
        S_SD
    } seq_st_e;

    function automatic logic [DW-1:0] pack_cfg(input cfg_t c);
        logic [DW-1:0] v;
        v = '0;
        v[PULSE_W-1:0] = c.pulses;
        v[STOP_B]      = c.stop_sel;
        v[TERM_B]      = c.term_imm;
        return v;
    endfunction

    function automatic cfg_t unpack_cfg(input logic [DW-1:0] v);
        cfg_t c;
        c.pulses   = v[PULSE_W-1:0];
        c.stop_sel = v[STOP_B];
        c.term_imm = v[TERM_B];
        return c;
    endfunction

endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/unstick_regs.sv
module unstick_regs
    import unstick_pkg::*;
#(
    parameter int DFLT_PULSES = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          seq_busy,
    input  logic          seq_stuck,
    output cfg_t          act_cfg,
    output logic          go,
    output logic          busy_all,
    output logic          load_pend
);
    localparam cfg_t CFG_RST = '{term_imm: 1'b0, stop_sel: 1'b1,
                                 pulses: PULSE_W'(DFLT_PULSES)};

    cfg_t shadow;
    logic go_q;

    assign busy_all = go_q | seq_busy;
    assign go       = go_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow    <= CFG_RST;
            act_cfg   <= CFG_RST;
            load_pend <= 1'b0;
            go_q      <= 1'b0;
        end else begin
            go_q <= 1'b0;
            if (wr_en && wr_addr == A_CTRL && wr_data[0] && !busy_all)
                go_q <= 1'b1;
            if (wr_en && wr_addr == A_CFG)
                shadow <= unpack_cfg(wr_data);
            if (load_pend && !busy_all) begin
                act_cfg   <= shadow;
                load_pend <= 1'b0;
            end
            if (wr_en && wr_addr == A_LOAD && wr_data[0])
                load_pend <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CFG:   rd_data = pack_cfg(shadow);
            A_LOAD:  rd_data[0] = load_pend;
            A_CTRL:  rd_data[1:0] = {seq_stuck, busy_all};
            default: rd_data = pack_cfg(act_cfg);
        endcase
    end
endmodule

// File: rtl/unstick_seq.sv
module unstick_seq
    import unstick_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  cfg_t act_cfg,
    input  logic sda_s,
    output logic busy,
    output logic stuck,
    output logic scl_oe,
    output logic sda_oe
);
    localparam int DIV_W = $clog2(HALF_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    seq_st_e            st, st_n;
    logic [DIV_W-1:0]   div;
    logic [PULSE_W-1:0] done_cnt;
    cfg_t               cap;
    logic               tick, last_pulse, scl_n, sda_n;

    assign tick       = (div == DIV_LAST);
    assign last_pulse = (cap.term_imm && sda_s) ||
                        ((done_cnt + 1'b1) == cap.pulses);

    always_comb begin
        st_n = st;
        case (st)
            S_IDLE: if (go) begin
                if (act_cfg.pulses != '0) st_n = S_LOW;
                else if (act_cfg.stop_sel) st_n = S_SA;
            end
            S_LOW:  if (tick) st_n = S_HIGH;
            S_HIGH: if (tick) begin
                if (!last_pulse)       st_n = S_LOW;
                else if (cap.stop_sel) st_n = S_SA;
                else                   st_n = S_IDLE;
            end
            S_SA:   if (tick) st_n = S_SB;
            S_SB:   if (tick) st_n = S_SC;
            S_SC:   if (tick) st_n = S_SD;
            S_SD:   if (tick) st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
        scl_n = (st_n == S_LOW) || (st_n == S_SA) || (st_n == S_SB);
        sda_n = (st_n == S_SB) || (st_n == S_SC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            div      <= '0;
            done_cnt <= '0;
            cap      <= '0;
            stuck    <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            st     <= st_n;
            scl_oe <= scl_n;
            sda_oe <= sda_n;
            if (st == S_IDLE || st_n != st) div <= '0;
            else                            div <= div + 1'b1;
            if (st == S_IDLE && go) begin
                cap      <= act_cfg;
                done_cnt <= '0;
                if (act_cfg.pulses == '0) stuck <= ~sda_s;
            end
            if (st == S_HIGH && tick) begin
                done_cnt <= done_cnt + 1'b1;
                stuck    <= ~sda_s;
            end
        end
    end

    assign busy = (st != S_IDLE);
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
    import unstick_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int DFLT_PULSES = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe
);
    cfg_t act_cfg;
    logic go, busy_all, load_pend, seq_busy, seq_stuck, sda_s;

    unstick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(sda_in), .q(sda_s)
    );

    unstick_regs #(.DFLT_PULSES(DFLT_PULSES)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .seq_busy(seq_busy), .seq_stuck(seq_stuck),
        .act_cfg(act_cfg), .go(go), .busy_all(busy_all),
        .load_pend(load_pend)
    );

    unstick_seq #(.HALF_DIV(HALF_DIV)) u_seq (
        .clk(clk), .rst(rst), .go(go), .act_cfg(act_cfg), .sda_s(sda_s),
        .busy(seq_busy), .stuck(seq_stuck),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );
endmodule

// File: rtl/unstick_chk.sv
module unstick_chk
    import unstick_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          scl_oe,
    input logic          sda_oe,
    input logic          seq_busy,
    input logic          go,
    input logic          busy_all,
    input logic          load_pend,
    input logic [DW-1:0] act_bits
);
    AST_SDA_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> scl_oe && $past(scl_oe)); // R4
    AST_SDA_FALL_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> !scl_oe && !$past(scl_oe)); // R4
    AST_SDA_STEADY_ON_SCL_EDGE: assert property (@(posedge clk) disable iff (rst)
        ($rose(scl_oe) || $fell(scl_oe)) |-> $stable(sda_oe)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !seq_busy |-> !scl_oe && !sda_oe); // R5
    AST_GO_IDLE: assert property (@(posedge clk) disable iff (rst)
        go |-> !seq_busy); // R5
    AST_LOAD_DEFER: assert property (@(posedge clk) disable iff (rst)
        $fell(load_pend) |-> !$past(busy_all)); // R7
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(seq_busy) |-> $stable(act_bits)); // R7
endmodule

bind i2c_unstick unstick_chk u_chk (
    .clk(clk), .rst(rst), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .seq_busy(seq_busy), .go(go), .busy_all(busy_all),
    .load_pend(load_pend), .act_bits(act_cfg)
);

// File: tb/test_i2c_unstick.sv
module test_i2c_unstick;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [5:0] rd_data;
    logic       sda_in;
    logic       scl_oe, sda_oe;

    int tests = 0, fails = 0;
    bit finished = 0;

    int rises = 0, sda_rises = 0, stops = 0, len = 0, w_first = 0;
    int base = 0, slave_k = 0;
    logic scl_prev = 1'b0, sda_prev = 1'b0;

    always #5 clk = ~clk;

    i2c_unstick i_i2c_unstick (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // slave holds SDA low until it has seen slave_k SCL falling edges
    assign sda_in = !(sda_oe || ((rises - base) < slave_k));

    always @(negedge clk) begin
        if (scl_oe && !scl_prev) rises <= rises + 1;
        if (sda_oe && !sda_prev) sda_rises <= sda_rises + 1;
        if (!sda_oe && sda_prev && !scl_oe) stops <= stops + 1;
        if (scl_oe) len <= len + 1;
        else begin
            if (scl_prev && (rises - base) == 1) w_first <= len;
            len <= 0;
        end
        scl_prev <= scl_oe;
        sda_prev <= sda_oe;
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic wait_idle();
        int v;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd2, v);
            if ((v & 1) == 0) return;
        end
        check("R5 busy timeout", 1, 0);
    endtask

    task automatic load_cfg(input int n, input bit stp, input bit trm);
        int v;
        wr(2'd0, {trm, stp, 4'(n)});
        wr(2'd1, 6'd1);
        for (int i = 0; i < 50; i++) begin
            rd(2'd1, v);
            if (v == 0) break;
        end
        check("R7 load clears", v, 0);
    endtask

    task automatic start_op();
        @(negedge clk);
        base = rises; w_first = 0;
        wr(2'd2, 6'd1);
    endtask

    task automatic finish_op(input string tag, input int n, input bit stp,
                             input int exp_p, input int exp_stuck);
        int v, r0, s0, st0;
        wait_idle();
        repeat (2) @(negedge clk);
        r0 = rises - base;
        check({tag, " pulses"}, r0 - (stp ? 1 : 0), exp_p);
        rd(2'd2, v);
        check("R8 stuck status", (v >> 1) & 1, exp_stuck);
        if (exp_p > 0) check("R9 scl low width", w_first, H);
        s0 = sda_rises; st0 = stops;
        s0 = s0; st0 = st0;
        if (n >= 0) ;
    endtask

    task automatic run_op(input int n, input int k, input bit stp, input bit trm);
        int exp_p, sr0, st0, mn;
        load_cfg(n, stp, trm);
        slave_k = k;
        repeat (4) @(negedge clk);
        sr0 = sda_rises; st0 = stops;
        start_op();
        mn = (k < n) ? k : n;
        if (mn < 1) mn = 1;
        exp_p = trm ? ((n == 0) ? 0 : mn) : n;
        finish_op(trm ? "R3" : "R2", n, stp, exp_p, (k > n) ? 1 : 0);
        check("R4 stop count", stops - st0, stp ? 1 : 0);
        check("R4 sda activity", sda_rises - sr0, stp ? 1 : 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v, st0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); check("R1 shadow reset", v, 'h19);
        rd(2'd3, v); check("R1 active reset", v, 'h19);
        rd(2'd2, v); check("R1 ctrl reset", v, 0);
        check("R1 scl_oe reset", int'(scl_oe), 0);
        check("R1 sda_oe reset", int'(sda_oe), 0);

        // R1 default configuration drives 9 pulses and a STOP
        slave_k = 0;
        st0 = stops;
        start_op();
        finish_op("R1 default", 9, 1, 9, 0);
        check("R1 default stop", stops - st0, 1);

        // R6 shadow write without load leaves active config alone
        wr(2'd0, 6'h05);
        rd(2'd3, v); check("R6 active unchanged", v, 'h19);
        rd(2'd0, v); check("R6 shadow written", v, 'h05);
        start_op();
        finish_op("R6 old count", 9, 1, 9, 0);

        // R5 writes during a run are ignored; R7 load deferred while busy
        slave_k = 20;
        st0 = stops;
        start_op();
        repeat (12) @(negedge clk);
        wr(2'd2, 6'd0);
        rd(2'd2, v); check("R5 busy after write 0", v & 1, 1);
        wr(2'd2, 6'd1);
        wr(2'd0, 6'h03);
        wr(2'd1, 6'd1);
        rd(2'd1, v); check("R7 load pending while busy", v, 1);
        rd(2'd3, v); check("R7 active held while busy", v, 'h19);
        finish_op("R5 uninterrupted", 9, 1, 9, 1);
        check("R5 single recovery", stops - st0, 1);
        rd(2'd1, v); check("R7 load done after run", v, 0);
        rd(2'd3, v); check("R7 active updated", v, 'h03);
        slave_k = 0;
        st0 = stops;
        start_op();
        finish_op("R7 new count", 3, 0, 3, 0);
        check("R7 no stop", stops - st0, 0);

        // sweep
        for (int n = 0; n <= 10; n++)
            for (int k = 0; k <= 12; k++)
                for (int m = 0; m < 4; m++)
                    run_op(n, k, m[0], m[1]);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule